// File: doc/BRIEF.md
# Iterative Single-Precision Floating-Point Adder

This unit adds or subtracts two single-precision operands supplied as raw 32-bit words and returns a packed 32-bit word after a variable number of clock cycles. A client raises `start` for one cycle while the unit is idle, with both operands present. The unit raises `busy` until its work is over and marks the valid result with a single-cycle `done` pulse. The result stays on `result` until the next operation finishes.

Internally a four-state machine controls the unit. IDLE waits for `start` and captures both words (transition IDLE to CALC). CALC unpacks the operands, restores each hidden one, aligns the smaller operand by a truncating right shift and adds or subtracts the magnitudes (transition CALC to NORM). NORM takes one normalisation step per cycle. It stays in NORM while a step moves the significand, and it moves to DONE once the significand is normalised or found to be zero, writing the packed result in the same edge. DONE drives the `done` pulse and always returns to IDLE. The arithmetic truncates: it keeps no guard, round or sticky bits. Subnormal inputs, infinities and NaNs are not handled.

Top module: `fp32_iter_adder`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` and `done` are 0 and `result` is 0x00000000.
- R2: An operand word is read as sign in bit 31, exponent in bits 30:23 and fraction in bits 22:0, with a one prepended above the fraction. The result is packed as {sign, exponent, low 23 bits of the normalised significand}.
- R3: The 24-bit significand of the operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are lost. The shift is limited to 24, so any difference of 24 or more contributes zero. The working exponent is the larger one.
- R4: When the two sign bits match, the significands are added and the result takes that sign.
- R5: When the signs differ, the smaller aligned significand is subtracted from the larger. The result takes the second operand's sign when its aligned significand is strictly larger, and the first operand's sign otherwise.
- R6: A sum of 0x1000000 or more is shifted right once and the exponent is incremented once. `done` then appears 4 cycles after the accepting edge.
- R7: A significand below 0x800000 is shifted left one bit per cycle, with the exponent decremented each time, until bit 23 is set. With n such shifts, `done` is seen 3+n clock edges after the edge that accepted `start`, and 3 edges when no shift is needed.
- R8: An all-zero significand ends normalisation at once, and the result is +0 (0x00000000) after 3 edges.
- R9: `busy` is high from the accepting edge through the `done` cycle. `done` is high for exactly one cycle.
- R10: `start` has no effect while `busy` is high. The result of the running operation is unchanged, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation; taken only in IDLE |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| busy | output | 1 | High while an operation is in progress, including the done cycle |
| done | output | 1 | One-cycle pulse marking a valid `result` |
| result | output | 32 | Packed sum, held until the next completion |

## Verification
Two events can fall in the same cycle: a new `start` request and the completion of the previous operation, when `done` is high and the machine is still in DONE. The bench places a `start` pulse carrying different operands in the exact cycle `done` is high, and another in the middle of a long normalisation. It then judges that `busy` drops right after the pulse, that no second `done` arrives in the following cycles, and that `result` still holds the first operation's value. The cycle counts of 3, 4 and 26 edges confirm that normalisation advances exactly one bit per clock.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    localparam int unsigned FP_EXP_W = 8;
    localparam int unsigned FP_MAN_W = 23;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_NORM = 2'd2,
        ST_DONE = 2'd3
    } add_state_t;
endpackage

// File: rtl/fpadd_align_addsub.sv
module fpadd_align_addsub #(
    parameter int unsigned EXP_W = fpadd_pkg::FP_EXP_W,
    parameter int unsigned MAN_W = fpadd_pkg::FP_MAN_W,
    localparam int unsigned SIG_W  = MAN_W + 1,
    localparam int unsigned WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic [SIG_W:0]    raw_sig,
    output logic [EXP_W-1:0]  raw_exp,
    output logic              raw_sign
);
    localparam logic [EXP_W-1:0] SHIFT_CAP = EXP_W'(SIG_W);

    logic             sgn_a, sgn_b;
    logic [EXP_W-1:0] exp_a, exp_b, gap, shamt;
    logic [SIG_W-1:0] sig_a, sig_b, al_a, al_b;

    always_comb begin
        sgn_a = word_a[WORD_W-1];
        sgn_b = word_b[WORD_W-1];
        exp_a = word_a[WORD_W-2 -: EXP_W];
        exp_b = word_b[WORD_W-2 -: EXP_W];
        sig_a = {1'b1, word_a[MAN_W-1:0]};
        sig_b = {1'b1, word_b[MAN_W-1:0]};

        if (exp_a >= exp_b) begin
            gap     = exp_a - exp_b;
            raw_exp = exp_a;
        end else begin
            gap     = exp_b - exp_a;
            raw_exp = exp_b;
        end
        shamt = (gap > SHIFT_CAP) ? SHIFT_CAP : gap;

        al_a = (exp_a >= exp_b) ? sig_a : (sig_a >> shamt);
        al_b = (exp_a >= exp_b) ? (sig_b >> shamt) : sig_b;

        if (sgn_a == sgn_b) begin
            raw_sig  = {1'b0, al_a} + {1'b0, al_b};
            raw_sign = sgn_a;
        end else if (al_b > al_a) begin
            raw_sig  = {1'b0, al_b - al_a};
            raw_sign = ~sgn_a;
        end else begin
            raw_sig  = {1'b0, al_a - al_b};
            raw_sign = sgn_a;
        end
    end
endmodule

// File: rtl/fpadd_norm_step.sv
module fpadd_norm_step #(
    parameter int unsigned EXP_W = fpadd_pkg::FP_EXP_W,
    parameter int unsigned MAN_W = fpadd_pkg::FP_MAN_W,
    localparam int unsigned SIG_W = MAN_W + 1
) (
    input  logic [SIG_W:0]   cur_sig,
    input  logic [EXP_W-1:0] cur_exp,
    output logic [SIG_W:0]   nxt_sig,
    output logic [EXP_W-1:0] nxt_exp,
    output logic             settled,
    output logic             is_zero
);
    always_comb begin
        nxt_sig = cur_sig;
        nxt_exp = cur_exp;
        settled = 1'b0;
        is_zero = 1'b0;
        if (cur_sig == '0) begin
            settled = 1'b1;
            is_zero = 1'b1;
        end else if (cur_sig[SIG_W]) begin
            nxt_sig = cur_sig >> 1;
            nxt_exp = cur_exp + 1'b1;
        end else if (cur_sig[SIG_W-1]) begin
            settled = 1'b1;
        end else begin
            nxt_sig = cur_sig << 1;
            nxt_exp = cur_exp - 1'b1;
        end
    end
endmodule

// File: rtl/fp32_iter_adder.sv
module fp32_iter_adder #(
    parameter int unsigned EXP_W = fpadd_pkg::FP_EXP_W,
    parameter int unsigned MAN_W = fpadd_pkg::FP_MAN_W,
    localparam int unsigned SIG_W  = MAN_W + 1,
    localparam int unsigned WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result
);
    import fpadd_pkg::*;

    add_state_t        state_q, state_d;
    logic [WORD_W-1:0] a_q, b_q, result_q;
    logic [SIG_W:0]    sig_q, raw_sig, step_sig;
    logic [EXP_W-1:0]  exp_q, raw_exp, step_exp;
    logic              sign_q, raw_sign, step_settled, step_zero;

    fpadd_align_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .word_a  (a_q),
        .word_b  (b_q),
        .raw_sig (raw_sig),
        .raw_exp (raw_exp),
        .raw_sign(raw_sign)
    );

    fpadd_norm_step #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_step (
        .cur_sig(sig_q),
        .cur_exp(exp_q),
        .nxt_sig(step_sig),
        .nxt_exp(step_exp),
        .settled(step_settled),
        .is_zero(step_zero)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CALC;
            ST_CALC: state_d = ST_NORM;
            ST_NORM: if (step_settled) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            sig_q    <= '0;
            exp_q    <= '0;
            sign_q   <= 1'b0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    a_q <= op_a;
                    b_q <= op_b;
                end
                ST_CALC: begin
                    sig_q  <= raw_sig;
                    exp_q  <= raw_exp;
                    sign_q <= raw_sign;
                end
                ST_NORM: begin
                    if (step_zero)         result_q <= '0;
                    else if (step_settled) result_q <= {sign_q, exp_q, sig_q[MAN_W-1:0]};
                    else begin
                        sig_q <= step_sig;
                        exp_q <= step_exp;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_DONE);
        result = result_q;
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_result_only_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
    assert_left_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && sig_q != '0 && !sig_q[SIG_W] && !sig_q[SIG_W-1])
        |=> (state_q == ST_NORM && exp_q == $past(exp_q) - 1'b1));
    assert_right_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && sig_q[SIG_W])
        |=> (state_q == ST_NORM && !sig_q[SIG_W] && exp_q == $past(exp_q) + 1'b1));
    assert_zero_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[WORD_W-2:0] == '0) |-> !result[WORD_W-1]);
endmodule

// File: tb/fp32_iter_adder_tb.sv
module fp32_iter_adder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done;
    logic [31:0] result;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fp32_iter_adder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    localparam int NV = 13;
    localparam logic [31:0] VA [NV] = '{
        32'h3FC00000, 32'h3F800000, 32'h40400000, 32'h3F800000, 32'hBF800000,
        32'hBFC00000, 32'h4B800000, 32'h53800000, 32'h3F800000, 32'h3F800000,
        32'h3FC00000, 32'hC0000000, 32'h40000000};
    localparam logic [31:0] VB [NV] = '{
        32'h3FE00000, 32'hBF800000, 32'hBF800000, 32'hC0400000, 32'h40400000,
        32'hBFE00000, 32'h3F800000, 32'h3F800000, 32'h34400000, 32'hBF7FFFFF,
        32'hC0400000, 32'h40000000, 32'h3F800000};
    localparam logic [31:0] VR [NV] = '{
        32'h40500000, 32'h00000000, 32'h40000000, 32'hC0000000, 32'h40000000,
        32'hC0500000, 32'h4B800000, 32'h53800000, 32'h3F800001, 32'h34000000,
        32'hBFC00000, 32'h00000000, 32'h40400000};
    localparam int VL [NV] = '{4, 3, 3, 3, 3, 4, 3, 3, 3, 26, 4, 3, 3};
    localparam string VT [NV] = '{
        "R6 overflow", "R8 cancel", "R5 a larger", "R5 b larger sign flip",
        "R5 neg a b larger", "R4 both negative", "R3 gap 24", "R3 gap capped",
        "R3 truncation", "R7 23 left shifts", "R7 one left shift", "R8 cancel neg a",
        "R2 packing"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic launch(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // waits for done; returns edges counted from the accepting edge
    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", {31'd0, busy}, 32'd0);
        check("R1 result in reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 result after reset", result, 32'd0);

        for (int i = 0; i < NV; i++) begin
            launch(VA[i], VB[i]);
            check({VT[i], " R9 busy"}, {31'd0, busy}, 32'd1);
            wait_done(lat);
            check({VT[i], " result"}, result, VR[i]);
            check({VT[i], " latency R7"}, lat, VL[i]);
            @(negedge clk);
            check({VT[i], " R9 single done"}, {30'd0, done, busy}, 32'd0);
        end

        // R10: start during normalisation
        launch(32'h3F800000, 32'hBF7FFFFF);
        repeat (4) @(negedge clk);
        op_a = 32'h40400000;
        op_b = 32'h3F800000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R10 result after mid-run start", result, 32'h34000000);
        check("R10 latency unchanged", lat, 26 - 6);

        // R10: start in the same cycle as done
        op_a = 32'h3FC00000;
        op_b = 32'h3FE00000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start at done", {31'd0, busy}, 32'd0);
        lat = 0;
        for (int k = 0; k < 10; k++) begin
            if (done || busy) lat++;
            @(negedge clk);
        end
        check("R10 no extra done", lat, 0);
        check("R10 result held", result, 32'h34000000);

        // R8 again after recovery from ignored requests
        launch(32'h40400000, 32'hC0400000);
        wait_done(lat);
        check("R8 zero after ignored starts", result, 32'h00000000);
        check("R8 zero latency", lat, 3);

        finish_run();
    end
endmodule